// File: doc/BRIEF.md
# Quick-Channel Trigger Word Mapper

This block provides eight quick DMA channels that are started by ordinary bus writes rather than by a start register or a peripheral request line. Each channel owns a map register that names one entry of a parameter memory (512 entries of 32 bytes, eight 32-bit words each) and one word within that entry. The block watches every write on the register bus. When a write lands on the mapped word of an enabled channel, it records a transfer event for that channel. It then hands that event to the transfer engine as a one-clock pulse that carries the channel number and the entry number.

Each channel has three per-channel flags. The enable flag is changed through a set port and a clear port. The secondary-event flag records an event that the engine has not yet acknowledged. The missed-event flag records a trigger that arrived while the previous event was still outstanding. A write that matches several channels at once produces one event per clock, starting with the lowest channel number. The transfer engine itself is outside this block.

Top module: `qtm_trigger_mapper`

## Requirements
- R1: After reset all map registers, enable flags, secondary-event flags and missed-event flags are zero, and `evt_valid_o` is low.
- R2: A write to byte address 0x200 + 4*ch loads the channel's map. Data bits 13:5 hold the entry number and bits 4:2 hold the word index. The other data bits are ignored. A map value of zero means the channel is unmapped.
- R3: A write to 0x300 sets each enable flag whose data bit (bit index = channel) is one. Bits written as zero leave their flag unchanged.
- R4: A write to 0x304 clears each enable flag whose data bit is one. Bits written as zero leave their flag unchanged.
- R5: A write to address 0x4000 + 32*entry + 4*word records an event on every enabled channel whose map holds that entry and word. The event sets the channel's secondary-event flag. In the clock after the write edge, `evt_valid_o` is high with `evt_ch_o` equal to the channel and `evt_entry_o` equal to the entry.
- R6: No event is recorded on a channel that is disabled, is unmapped, or is mapped to a different entry or word. No event is recorded for any write outside 0x4000..0x7FFF.
- R7: A trigger on a channel whose secondary-event flag is already set issues no event and sets that channel's missed-event flag instead.
- R8: An acknowledge (`ack_i` together with `ack_ch_i`) clears that channel's secondary-event flag. A write to 0x308 clears the secondary-event flags whose data bits are one. A write to 0x30C clears the missed-event flags whose data bits are one. Zero bits leave the flags unchanged.
- R9: When one write matches several channels, their events are issued on consecutive clocks in ascending channel order.
- R10: Each event is presented for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 16 | Bus write byte address |
| wr_data_i | input | 32 | Bus write data |
| ack_i | input | 1 | Engine acknowledge strobe |
| ack_ch_i | input | 3 | Channel being acknowledged |
| evt_valid_o | output | 1 | Event pulse |
| evt_ch_o | output | 3 | Channel of the event |
| evt_entry_o | output | 9 | Parameter entry of the event |
| chan_en_o | output | 8 | Enable flags, one per channel |
| sec_evt_o | output | 8 | Secondary-event flags |
| miss_evt_o | output | 8 | Missed-event flags |

## Verification
The bench writes to a neighbouring word of the mapped entry and to the same word of a neighbouring entry. A comparator that ignored either field would fire on those writes. It triggers a channel a second time before acknowledging it. A design that queued the trigger instead of flagging it would emit a second pulse and leave the missed-event flag clear. It maps two channels to one word and checks for two pulses in ascending order on consecutive clocks. A wrong arbiter would reorder the pulses, merge them or repeat one. It also writes all-zero data to the set and clear ports, and remaps a channel to zero. A design that treated those writes as masks to load, or that compared an unmapped channel's zero map, would change flags or fire on entry 0.

// File: rtl/qtm_pkg.sv
package qtm_pkg;
   // Bytes in one parameter entry: eight 32-bit words.
   localparam int unsigned ENTRY_BYTES = 32;
   localparam int unsigned WORD_IDX_W  = 3;

   // Default register layout of the control window.
   localparam logic [15:0] DEF_MAP_BASE   = 16'h0200;
   localparam logic [15:0] DEF_EN_SET     = 16'h0300;
   localparam logic [15:0] DEF_EN_CLR     = 16'h0304;
   localparam logic [15:0] DEF_SEC_CLR    = 16'h0308;
   localparam logic [15:0] DEF_MISS_CLR   = 16'h030C;
   localparam logic [15:0] DEF_PARAM_BASE = 16'h4000;

   typedef enum logic [2:0] {
      CTL_NONE,
      CTL_EN_SET,
      CTL_EN_CLR,
      CTL_SEC_CLR,
      CTL_MISS_CLR
   } ctl_reg_e;
endpackage

// File: rtl/qtm_regs.sv
module qtm_regs
   import qtm_pkg::*;
#(
   parameter int unsigned NUM_CH        = 8,
   parameter int unsigned CH_W          = 3,
   parameter int unsigned ENTRY_W       = 9,
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned DATA_W        = 32,
   parameter logic [ADDR_W-1:0] MAP_BASE     = DEF_MAP_BASE,
   parameter logic [ADDR_W-1:0] EN_SET_ADDR  = DEF_EN_SET,
   parameter logic [ADDR_W-1:0] EN_CLR_ADDR  = DEF_EN_CLR,
   parameter logic [ADDR_W-1:0] SEC_CLR_ADDR = DEF_SEC_CLR,
   parameter logic [ADDR_W-1:0] MISS_CLR_ADDR = DEF_MISS_CLR
) (
   input  logic                                          clk_i,
   input  logic                                          rst_ni,
   input  logic                                          wr_en_i,
   input  logic [ADDR_W-1:0]                             wr_addr_i,
   input  logic [DATA_W-1:0]                             wr_data_i,
   output logic [NUM_CH-1:0][ENTRY_W+WORD_IDX_W-1:0]     map_o,
   output logic [NUM_CH-1:0]                             en_o,
   output logic [NUM_CH-1:0]                             sec_clr_o,
   output logic [NUM_CH-1:0]                             miss_clr_o
);
   localparam int unsigned MAP_W = ENTRY_W + WORD_IDX_W;

   logic [ADDR_W-1:0] map_off;
   logic              map_hit;
   logic [CH_W-1:0]   map_idx;
   ctl_reg_e          ctl_sel;
   logic [NUM_CH-1:0] wr_bits;
   logic [NUM_CH-1:0] set_mask, clr_mask;
   logic [NUM_CH-1:0] en_q;
   logic              unused_data;

   assign unused_data = ^wr_data_i;
   assign wr_bits     = wr_data_i[NUM_CH-1:0];

   // Map register window: one word per channel, word aligned.
   assign map_off = wr_addr_i - MAP_BASE;
   assign map_hit = wr_en_i && (wr_addr_i >= MAP_BASE) &&
                    (map_off < ADDR_W'(NUM_CH * 4)) && (map_off[1:0] == 2'b00);
   assign map_idx = map_off[CH_W+1:2];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_map
      logic [MAP_W-1:0] map_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni)
            map_q <= '0;
         else if (map_hit && (map_idx == CH_W'(c)))
            map_q <= wr_data_i[MAP_W+1:2];
      end
      assign map_o[c] = map_q;
   end

   // Flag control ports.
   always_comb begin
      ctl_sel = CTL_NONE;
      if (wr_en_i) begin
         case (wr_addr_i)
            EN_SET_ADDR:   ctl_sel = CTL_EN_SET;
            EN_CLR_ADDR:   ctl_sel = CTL_EN_CLR;
            SEC_CLR_ADDR:  ctl_sel = CTL_SEC_CLR;
            MISS_CLR_ADDR: ctl_sel = CTL_MISS_CLR;
            default:       ctl_sel = CTL_NONE;
         endcase
      end
   end

   assign set_mask   = (ctl_sel == CTL_EN_SET)   ? wr_bits : '0;
   assign clr_mask   = (ctl_sel == CTL_EN_CLR)   ? wr_bits : '0;
   assign sec_clr_o  = (ctl_sel == CTL_SEC_CLR)  ? wr_bits : '0;
   assign miss_clr_o = (ctl_sel == CTL_MISS_CLR) ? wr_bits : '0;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         en_q <= '0;
      else
         en_q <= (en_q | set_mask) & ~clr_mask;
   end
   assign en_o = en_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_en_chk
      // R3: a one written to the set port turns the flag on.
      a_r3_set_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (wr_en_i && wr_addr_i == EN_SET_ADDR && wr_data_i[c]) |=> en_o[c]);
      // R4: a one written to the clear port turns the flag off.
      a_r4_clr_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (wr_en_i && wr_addr_i == EN_CLR_ADDR && wr_data_i[c]) |=> !en_o[c]);
   end
endmodule

// File: rtl/qtm_match.sv
module qtm_match
   import qtm_pkg::*;
#(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned ENTRY_W = 9,
   parameter int unsigned ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] PARAM_BASE = DEF_PARAM_BASE
) (
   input  logic                                      wr_en_i,
   input  logic [ADDR_W-1:0]                         wr_addr_i,
   input  logic [NUM_CH-1:0][ENTRY_W+WORD_IDX_W-1:0] map_i,
   input  logic [NUM_CH-1:0]                         en_i,
   output logic [NUM_CH-1:0]                         hit_o,
   output logic [ENTRY_W-1:0]                        wr_entry_o
);
   localparam int unsigned MAP_W      = ENTRY_W + WORD_IDX_W;
   localparam int unsigned SPAN_BYTES = ENTRY_BYTES << ENTRY_W;

   logic [ADDR_W-1:0] off;
   logic              in_win;
   logic [MAP_W-1:0]  field;
   logic              unused_off;

   assign off        = wr_addr_i - PARAM_BASE;
   assign in_win     = wr_en_i && (wr_addr_i >= PARAM_BASE) && (32'(off) < SPAN_BYTES);
   assign field      = off[MAP_W+1:2];
   assign wr_entry_o = field[MAP_W-1:WORD_IDX_W];
   assign unused_off = ^off;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
      assign hit_o[c] = in_win && en_i[c] && (map_i[c] != '0) && (map_i[c] == field);
   end
endmodule

// File: rtl/qtm_evt.sv
module qtm_evt #(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned CH_W    = 3,
   parameter int unsigned ENTRY_W = 9
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [NUM_CH-1:0]      hit_i,
   input  logic [ENTRY_W-1:0]     wr_entry_i,
   input  logic                   ack_i,
   input  logic [CH_W-1:0]        ack_ch_i,
   input  logic [NUM_CH-1:0]      sec_clr_i,
   input  logic [NUM_CH-1:0]      miss_clr_i,
   output logic                   evt_valid_o,
   output logic [CH_W-1:0]        evt_ch_o,
   output logic [ENTRY_W-1:0]     evt_entry_o,
   output logic [NUM_CH-1:0]      sec_o,
   output logic [NUM_CH-1:0]      miss_o
);
   logic [NUM_CH-1:0]              sec_q, miss_q, pend_q;
   logic [NUM_CH-1:0]              rec, dup, ack_mask, issue;
   logic [NUM_CH-1:0][ENTRY_W-1:0] entry_q;
   logic [CH_W-1:0]                sel;
   logic                           any;

   assign rec = hit_i & ~sec_q;
   assign dup = hit_i & sec_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ack
      assign ack_mask[c] = ack_i && (ack_ch_i == CH_W'(c));
   end

   // Lowest pending channel goes first.
   always_comb begin
      sel = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (pend_q[i]) sel = CH_W'(i);
      end
   end
   assign any   = |pend_q;
   assign issue = any ? (NUM_CH'(1) << sel) : '0;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sec_q  <= '0;
         miss_q <= '0;
         pend_q <= '0;
      end else begin
         sec_q  <= (sec_q & ~ack_mask & ~sec_clr_i) | rec;
         miss_q <= (miss_q & ~miss_clr_i) | dup;
         pend_q <= (pend_q & ~issue) | rec;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_entry
      always_ff @(posedge clk_i) begin
         if (!rst_ni)
            entry_q[c] <= '0;
         else if (rec[c])
            entry_q[c] <= wr_entry_i;
      end
   end

   assign evt_valid_o = any;
   assign evt_ch_o    = sel;
   assign evt_entry_o = entry_q[sel];
   assign sec_o       = sec_q;
   assign miss_o      = miss_q;

   // R10: the same channel is never presented on two clocks in a row.
   a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_valid_o |=> !(evt_valid_o && evt_ch_o == $past(evt_ch_o)));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      // R7: a missed flag only rises when the secondary flag was set.
      a_r7_miss_needs_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(miss_o[c]) |-> $past(sec_o[c]));
      // R8: acknowledge drops a set secondary flag.
      a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (ack_i && ack_ch_i == CH_W'(c) && sec_o[c]) |=> !sec_o[c]);
   end
endmodule

// File: rtl/qtm_trigger_mapper.sv
module qtm_trigger_mapper
   import qtm_pkg::*;
#(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned ENTRY_W = 9,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DATA_W  = 32,
   parameter logic [ADDR_W-1:0] MAP_BASE      = DEF_MAP_BASE,
   parameter logic [ADDR_W-1:0] EN_SET_ADDR   = DEF_EN_SET,
   parameter logic [ADDR_W-1:0] EN_CLR_ADDR   = DEF_EN_CLR,
   parameter logic [ADDR_W-1:0] SEC_CLR_ADDR  = DEF_SEC_CLR,
   parameter logic [ADDR_W-1:0] MISS_CLR_ADDR = DEF_MISS_CLR,
   parameter logic [ADDR_W-1:0] PARAM_BASE    = DEF_PARAM_BASE,
   localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_en_i,
   input  logic [ADDR_W-1:0]  wr_addr_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   input  logic               ack_i,
   input  logic [CH_W-1:0]    ack_ch_i,
   output logic               evt_valid_o,
   output logic [CH_W-1:0]    evt_ch_o,
   output logic [ENTRY_W-1:0] evt_entry_o,
   output logic [NUM_CH-1:0]  chan_en_o,
   output logic [NUM_CH-1:0]  sec_evt_o,
   output logic [NUM_CH-1:0]  miss_evt_o
);
   localparam int unsigned MAP_W = ENTRY_W + WORD_IDX_W;

   initial begin
      assert (NUM_CH >= 1 && NUM_CH <= DATA_W)
         else $error("qtm: channel count must fit in one data word");
      assert (MAP_W + 2 <= DATA_W)
         else $error("qtm: map field does not fit in the data word");
      assert (32'(PARAM_BASE) + (ENTRY_BYTES << ENTRY_W) <= (64'd1 << ADDR_W))
         else $error("qtm: parameter window exceeds the address space");
   end

   logic [NUM_CH-1:0][MAP_W-1:0] map;
   logic [NUM_CH-1:0]            en, hit, sec_clr, miss_clr;
   logic [ENTRY_W-1:0]           wr_entry;

   qtm_regs #(
      .NUM_CH(NUM_CH), .CH_W(CH_W), .ENTRY_W(ENTRY_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .MAP_BASE(MAP_BASE), .EN_SET_ADDR(EN_SET_ADDR), .EN_CLR_ADDR(EN_CLR_ADDR),
      .SEC_CLR_ADDR(SEC_CLR_ADDR), .MISS_CLR_ADDR(MISS_CLR_ADDR)
   ) regs_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .map_o(map), .en_o(en), .sec_clr_o(sec_clr),
      .miss_clr_o(miss_clr)
   );

   qtm_match #(
      .NUM_CH(NUM_CH), .ENTRY_W(ENTRY_W), .ADDR_W(ADDR_W), .PARAM_BASE(PARAM_BASE)
   ) match_i (
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .map_i(map), .en_i(en),
      .hit_o(hit), .wr_entry_o(wr_entry)
   );

   qtm_evt #(
      .NUM_CH(NUM_CH), .CH_W(CH_W), .ENTRY_W(ENTRY_W)
   ) evt_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .wr_entry_i(wr_entry),
      .ack_i(ack_i), .ack_ch_i(ack_ch_i), .sec_clr_i(sec_clr), .miss_clr_i(miss_clr),
      .evt_valid_o(evt_valid_o), .evt_ch_o(evt_ch_o), .evt_entry_o(evt_entry_o),
      .sec_o(sec_evt_o), .miss_o(miss_evt_o)
   );

   assign chan_en_o = en;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_top_chk
      // R6: a secondary flag only rises for a channel that was enabled.
      a_r6_sec_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(sec_evt_o[c]) |-> $past(chan_en_o[c]));
      // R5: a recorded trigger raises the secondary flag.
      a_r5_sec_on_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (hit[c] && !sec_evt_o[c]) |=> sec_evt_o[c]);
   end
endmodule

// File: tb/qtm_trigger_mapper_tb_top.sv
module qtm_trigger_mapper_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        ack = 1'b0;
   logic [2:0]  ack_ch = '0;
   logic        evt_valid;
   logic [2:0]  evt_ch;
   logic [8:0]  evt_entry;
   logic [7:0]  chan_en, sec_evt, miss_evt;

   int unsigned n_chk = 0;
   int unsigned n_fail = 0;
   int unsigned cyc = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   qtm_trigger_mapper dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .ack_i(ack), .ack_ch_i(ack_ch),
      .evt_valid_o(evt_valid), .evt_ch_o(evt_ch), .evt_entry_o(evt_entry),
      .chan_en_o(chan_en), .sec_evt_o(sec_evt), .miss_evt_o(miss_evt)
   );

   typedef struct packed {
      logic [15:0] addr;
      logic        v;
      logic [2:0]  ch;
      logic [8:0]  ent;
   } vec_t;

   // Trigger writes and the event each must produce (v=0: none).
   localparam vec_t VECS [7] = '{
      '{16'h40AC, 1'b1, 3'd0, 9'd5},     // ch0 entry 5 word 3
      '{16'h40A8, 1'b0, 3'd0, 9'd0},     // neighbouring word
      '{16'h40CC, 1'b0, 3'd0, 9'd0},     // neighbouring entry
      '{16'h7FFC, 1'b1, 3'd2, 9'd511},   // ch2 last entry last word
      '{16'h4020, 1'b1, 3'd7, 9'd1},     // ch7 entry 1 word 0
      '{16'h00AC, 1'b0, 3'd0, 9'd0},     // below the window
      '{16'h8000, 1'b0, 3'd0, 9'd0}      // above the window
   };

   function automatic logic [31:0] evt_word();
      return evt_valid ? {19'd0, 1'b1, evt_ch, evt_entry} : 32'd0;
   endfunction

   function automatic logic [31:0] exp_word(logic v, logic [2:0] ch, logic [8:0] ent);
      return v ? {19'd0, 1'b1, ch, ent} : 32'd0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Returns at the falling edge after the write edge.
   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
   endtask

   task automatic do_ack(input logic [2:0] ch);
      ack = 1'b1; ack_ch = ch;
      @(negedge clk);
      ack = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 evt", evt_word(), 32'd0);
      chk("R1 flags", {8'd0, chan_en, sec_evt, miss_evt}, 32'd0);

      // R2: maps (upper data bits must be ignored on ch0)
      wr(16'h0200, 32'hFFFF_C0AC);   // ch0 entry 5 word 3
      wr(16'h0204, 32'h0000_00AC);   // ch1 same word, left disabled
      wr(16'h0208, 32'h0000_3FFC);   // ch2 entry 511 word 7
      wr(16'h021C, 32'h0000_0020);   // ch7 entry 1 word 0
      // R3: enable 0,2,7
      wr(16'h0300, 32'h0000_0085);
      chk("R3 set", {24'd0, chan_en}, 32'h85);
      wr(16'h0300, 32'h0000_0000);
      chk("R3 zero no effect", {24'd0, chan_en}, 32'h85);

      // R5 R6 R2: table walk
      for (int i = 0; i < 7; i++) begin
         wr(VECS[i].addr, 32'h1234_5678);
         chk($sformatf("R5/R6 vec%0d", i), evt_word(),
             exp_word(VECS[i].v, VECS[i].ch, VECS[i].ent));
         if (VECS[i].v) begin
            chk($sformatf("R5 sec vec%0d", i), {24'd0, sec_evt},
                32'(8'h01 << VECS[i].ch));
            do_ack(VECS[i].ch);
            chk($sformatf("R8 ack vec%0d", i), {24'd0, sec_evt}, 32'd0);
         end else begin
            @(negedge clk);
         end
      end

      // R7 R10: retrigger before acknowledge
      wr(16'h40AC, 32'd0);
      chk("R5 first", evt_word(), exp_word(1'b1, 3'd0, 9'd5));
      @(negedge clk);
      chk("R10 one clock", evt_word(), 32'd0);
      wr(16'h40AC, 32'd0);
      chk("R7 no second evt", evt_word(), 32'd0);
      chk("R7 miss set", {24'd0, miss_evt}, 32'h01);
      chk("R7 sec kept", {24'd0, sec_evt}, 32'h01);
      do_ack(3'd0);
      wr(16'h030C, 32'd0);
      chk("R8 miss zero write", {24'd0, miss_evt}, 32'h01);
      wr(16'h030C, 32'h01);
      chk("R8 miss clear", {24'd0, miss_evt}, 32'h00);

      // R9: ch0 and ch1 share a word
      wr(16'h0300, 32'h02);
      wr(16'h40AC, 32'd0);
      chk("R9 first ch0", evt_word(), exp_word(1'b1, 3'd0, 9'd5));
      @(negedge clk);
      chk("R9 second ch1", evt_word(), exp_word(1'b1, 3'd1, 9'd5));
      @(negedge clk);
      chk("R9 R10 drained", evt_word(), 32'd0);
      chk("R9 both sec", {24'd0, sec_evt}, 32'h03);
      do_ack(3'd0);
      do_ack(3'd1);

      // R4: disable ch0, ch1 still fires
      wr(16'h0304, 32'h01);
      chk("R4 clear", {24'd0, chan_en}, 32'h86);
      wr(16'h0304, 32'h00);
      chk("R4 zero no effect", {24'd0, chan_en}, 32'h86);
      wr(16'h40AC, 32'd0);
      chk("R4 R6 only ch1", evt_word(), exp_word(1'b1, 3'd1, 9'd5));
      @(negedge clk);
      chk("R6 ch0 disabled", evt_word(), 32'd0);
      do_ack(3'd1);

      // R8: software clear of secondary flag
      wr(16'h7FFC, 32'd0);
      chk("R5 ch2 again", evt_word(), exp_word(1'b1, 3'd2, 9'd511));
      wr(16'h0308, 32'h00);
      chk("R8 sec zero write", {24'd0, sec_evt}, 32'h04);
      wr(16'h0308, 32'h04);
      chk("R8 sec clear", {24'd0, sec_evt}, 32'h00);

      // R2 R6: unmapping ch7
      wr(16'h021C, 32'd0);
      wr(16'h4020, 32'd0);
      chk("R6 unmapped old word", evt_word(), 32'd0);
      wr(16'h4000, 32'd0);
      chk("R6 unmapped entry0", evt_word(), 32'd0);
      chk("R6 no flags", {16'd0, sec_evt, miss_evt}, 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule